// File: doc/BRIEF.md
# SPI Serial Memory Command Controller

This block is the target-side front end of a byte-addressed nonvolatile serial memory. A host selects it with an active-low chip select and exchanges bytes, most significant bit first, over a serial clock. The block works in SPI modes 0 and 3. All four serial pins are sampled by the block's own system clock. Incoming bits are taken on rising serial-clock edges, and read data moves to the output on falling edges. The first byte of every select window is a command byte. Memory commands follow it with a three-byte address and any number of data bytes. A write lands in the internal byte array the moment its eighth bit arrives, so the host never has to poll for completion.

The control path is one state machine with these states:
- ST_IDLE: deselected.
- ST_OPCODE: collecting the command byte.
- ST_ADDR: collecting the three address bytes.
- ST_RDATA: streaming array data out.
- ST_WDATA: storing incoming data.
- ST_STAT_RD: streaming the status byte out.
- ST_STAT_WR: taking one status byte in.
- ST_IGNORE: discarding traffic until the select is released.

Transitions:
- Any state moves to ST_IDLE when select rises, and to ST_OPCODE when select falls.
- From ST_OPCODE the command byte chooses the next state:
  - read goes to ST_ADDR;
  - write goes to ST_ADDR when writes are enabled, and to ST_IGNORE otherwise;
  - status read goes to ST_STAT_RD;
  - status write goes to ST_STAT_WR;
  - every other byte goes to ST_IGNORE.
- ST_ADDR goes to ST_RDATA or ST_WDATA after its third byte.
- ST_STAT_WR goes to ST_IGNORE after its byte.

A hold input freezes all of the above and releases the output.

Top module: `spimem_ctrl`

## Requirements
- R1: The serial input is sampled on rising serial-clock edges and read data changes only after falling edges. All bytes are sent MSB first. Both clock idle levels work: low (mode 0) and high (mode 3).
- R2: Command codes are enable-writes 0x06, disable-writes 0x04, status read 0x05, status write 0x01, read 0x03, write 0x02 and sleep 0xB9. Only the first byte of a select window is decoded. Later bytes in the same window never start a new command.
- R3: Enable-writes sets the write-enable flag, which is status bit 1. After a disable-writes, a status write or an accepted write command, the flag clears when select rises.
- R4: A write command is accepted only while the write-enable flag is 1. Each data byte is stored into the array when its eighth bit is received.
- R5: Read and write commands take a 24-bit address, most significant byte first. Only the low ADDR_W bits are used; the upper bits are ignored.
- R6: The address advances by one after every data byte in both directions. It wraps from the top location to 0.
- R7: A status read returns {keep[5:0], write-enable, 0}. A status write stores bits 7:2 into keep only while the write-enable flag is 1. Bits 1:0 of the written byte have no effect.
- R8: spi_miso_oe is 1 only while select is low, hold is high and a read or status-read byte is being shifted out.
- R9: While hold is low, clock and select transitions are ignored, the transfer state is frozen and spi_miso_oe is 0. The transfer resumes intact when hold returns high.
- R10: The sleep command sets sleep_flag at the end of its byte. The flag clears on the next select falling edge.
- R11: An unknown command byte makes the block ignore the rest of that select window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_hold_n | input | 1 | Active-low transfer pause |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for spi_miso (0 = high impedance) |
| sleep_flag | output | 1 | Set by the sleep command |

## Verification
The bench builds the block with ADDR_W = 4, a sixteen-byte array. With so few locations, a two-byte burst starting at address 15 crosses the wrap point. A 24-bit address such as 0xABCDE3 then aliases onto location 3, which shows directly that the upper address bits are dropped. Even with this small array, every command, both clock idle levels and a hold placed in the middle of a byte are exercised.

// File: rtl/spimem_pkg.sv
package spimem_pkg;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_SLEEP = 8'hB9;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPCODE, ST_ADDR, ST_RDATA,
        ST_WDATA, ST_STAT_RD, ST_STAT_WR, ST_IGNORE
    } state_t;
endpackage

// File: rtl/spimem_pins.sv
module spimem_pins (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic hold_n,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic live,
    output logic held,
    output logic mosi_s
);
    logic sck_s, cs_s, hold_s, sck_p, cs_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_s  <= 1'b0;
            cs_s   <= 1'b1;
            hold_s <= 1'b1;
            mosi_s <= 1'b0;
            sck_p  <= 1'b0;
            cs_p   <= 1'b1;
        end else begin
            sck_s  <= sck;
            cs_s   <= cs_n;
            hold_s <= hold_n;
            mosi_s <= mosi;
            sck_p  <= sck_s;
            // select history freezes during hold so edges there are never seen
            if (hold_s) cs_p <= cs_s;
        end
    end

    assign live     = hold_s & ~cs_s;
    assign held     = ~hold_s;
    assign sck_rise = live & sck_s & ~sck_p;
    assign sck_fall = live & ~sck_s & sck_p;
    assign cs_fall  = hold_s & cs_p & ~cs_s;
    assign cs_rise  = hold_s & ~cs_p & cs_s;
endmodule

// File: rtl/spimem_array.sv
module spimem_array #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/spimem_ctrl.sv
module spimem_ctrl #(
    parameter int ADDR_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_hold_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe,
    output logic sleep_flag
);
    import spimem_pkg::*;

    localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    state_t state, nxt;
    logic sck_rise, sck_fall, cs_fall, cs_rise, live, held, mosi_s;
    logic [2:0] bit_cnt;
    logic [1:0] addr_cnt;
    logic [7:0] sh_in, out_sh, rx_byte, rd_data, status;
    logic [15:0] addr_sh;
    logic [23:0] full_addr;
    logic [ADDR_W-1:0] addr;
    logic [5:0] keep;
    logic is_rd, wel, wel_clr, out_live, byte_done, mem_we, rd_state;

    spimem_pins u_pins (
        .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n),
        .hold_n(spi_hold_n), .mosi(spi_mosi), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .live(live), .held(held), .mosi_s(mosi_s)
    );

    spimem_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .we(mem_we), .waddr(addr), .wdata(rx_byte),
        .raddr(addr), .rdata(rd_data)
    );

    assign rx_byte   = {sh_in[6:0], mosi_s};
    assign full_addr = {addr_sh, rx_byte};
    assign byte_done = sck_rise & (bit_cnt == 3'd7) & ~cs_fall;
    assign mem_we    = byte_done & (state == ST_WDATA);
    assign status    = {keep, wel, 1'b0};
    assign rd_state  = (state == ST_RDATA) || (state == ST_STAT_RD);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state decode
    always_comb begin
        nxt = state;
        if (cs_rise)      nxt = ST_IDLE;
        else if (cs_fall) nxt = ST_OPCODE;
        else if (byte_done) begin
            unique case (state)
                ST_OPCODE: begin
                    case (rx_byte)
                        OP_READ:  nxt = ST_ADDR;
                        OP_WRITE: nxt = wel ? ST_ADDR : ST_IGNORE;
                        OP_RDSR:  nxt = ST_STAT_RD;
                        OP_WRSR:  nxt = ST_STAT_WR;
                        default:  nxt = ST_IGNORE;
                    endcase
                end
                ST_ADDR:    if (addr_cnt == 2'd2) nxt = is_rd ? ST_RDATA : ST_WDATA;
                ST_STAT_WR: nxt = ST_IGNORE;
                default:    ;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            addr_cnt   <= '0;
            sh_in      <= '0;
            addr_sh    <= '0;
            addr       <= '0;
            out_sh     <= '0;
            keep       <= '0;
            is_rd      <= 1'b0;
            wel        <= 1'b0;
            wel_clr    <= 1'b0;
            out_live   <= 1'b0;
            sleep_flag <= 1'b0;
        end else if (cs_fall) begin
            bit_cnt    <= '0;
            addr_cnt   <= '0;
            out_live   <= 1'b0;
            wel_clr    <= 1'b0;
            sleep_flag <= 1'b0;
        end else if (cs_rise) begin
            out_live <= 1'b0;
            wel_clr  <= 1'b0;
            if (wel_clr) wel <= 1'b0;
        end else begin
            if (sck_rise) begin
                sh_in   <= rx_byte;
                bit_cnt <= bit_cnt + 3'd1;
            end
            if (byte_done) begin
                unique case (state)
                    ST_OPCODE: begin
                        case (rx_byte)
                            OP_WREN:  wel <= 1'b1;
                            OP_WRDI:  wel_clr <= 1'b1;
                            OP_WRSR:  wel_clr <= 1'b1;
                            OP_READ:  is_rd <= 1'b1;
                            OP_WRITE: begin
                                is_rd <= 1'b0;
                                if (wel) wel_clr <= 1'b1;
                            end
                            OP_SLEEP: sleep_flag <= 1'b1;
                            default:  ;
                        endcase
                    end
                    ST_ADDR: begin
                        addr_sh  <= full_addr[15:0];
                        addr_cnt <= addr_cnt + 2'd1;
                        if (addr_cnt == 2'd2) addr <= full_addr[ADDR_W-1:0];
                    end
                    ST_RDATA, ST_WDATA: addr <= addr + ADDR_ONE;
                    ST_STAT_WR: if (wel) keep <= rx_byte[7:2];
                    default: ;
                endcase
            end
            if (sck_fall && rd_state) begin
                if (bit_cnt == 3'd0) begin
                    out_sh   <= (state == ST_RDATA) ? rd_data : status;
                    out_live <= 1'b1;
                end else begin
                    out_sh <= {out_sh[6:0], 1'b0};
                end
            end
        end
    end

    assign spi_miso    = out_sh[7];
    assign spi_miso_oe = live & out_live & rd_state;
endmodule

// File: rtl/spimem_ctrl_chk.sv
module spimem_ctrl_chk #(
    parameter int ADDR_W = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 spi_cs_n,
    input logic                 spi_hold_n,
    input logic                 spi_miso,
    input logic                 spi_miso_oe,
    input logic                 sleep_flag,
    input logic                 cs_fall,
    input logic                 sck_fall,
    input logic                 held,
    input logic                 byte_done,
    input spimem_pkg::state_t   state,
    input logic [2:0]           bit_cnt,
    input logic [ADDR_W-1:0]    addr
);
    import spimem_pkg::*;

    AST_OE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_oe |-> (!$past(spi_cs_n) && $past(spi_hold_n))); // R8

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> ($stable(state) && $stable(bit_cnt) && $stable(addr))); // R9

    AST_HOLD_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !spi_miso_oe); // R9

    AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> !sleep_flag); // R10

    AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && (state == ST_RDATA || state == ST_WDATA) && (&addr))
        |=> (addr == '0)); // R6

    AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(spi_miso)); // R1
endmodule

bind spimem_ctrl spimem_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_hold_n(spi_hold_n),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .sleep_flag(sleep_flag),
    .cs_fall(cs_fall), .sck_fall(sck_fall), .held(held),
    .byte_done(byte_done), .state(state), .bit_cnt(bit_cnt), .addr(addr)
);

// File: tb/spimem_ctrl_test.sv
module spimem_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, mosi = 1'b0;
    logic miso, miso_oe, sleep_flag;
    int   n_run = 0, n_fail = 0;
    bit   done = 1'b0;

    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    spimem_ctrl #(.ADDR_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_hold_n(hold_n), .spi_mosi(mosi), .spi_miso(miso),
        .spi_miso_oe(miso_oe), .sleep_flag(sleep_flag)
    );

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0) begin
                logic [7:0] g, e;
                string t;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(g === e, t, g, e);
            end
        end
    end

    task automatic sel(input bit mode3);
        sck = mode3;
        wclk(3);
        cs_n = 1'b0;
        wclk(4);
    endtask

    task automatic desel(input bit mode3);
        if (!mode3) sck = 1'b0;
        else        sck = 1'b1;
        wclk(4);
        cs_n = 1'b1;
        wclk(4);
    endtask

    task automatic xfer(input logic [7:0] tx, input int hold_bit,
                        output logic [7:0] rx, output bit oe_seen);
        oe_seen = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sck  = 1'b0;
            mosi = tx[i];
            wclk(4);
            if (i == hold_bit) begin
                hold_n = 1'b0;
                wclk(4);
                chk(miso_oe == 1'b0, "R9 oe during hold", miso_oe, 0);
                for (int k = 0; k < 2; k++) begin
                    sck = 1'b1; wclk(3);
                    sck = 1'b0; wclk(3);
                end
                cs_n = 1'b1; wclk(3);
                cs_n = 1'b0; wclk(3);
                hold_n = 1'b1;
                wclk(4);
            end
            rx[i] = miso;
            if (miso_oe) oe_seen = 1'b1;
            sck = 1'b1;
            wclk(4);
        end
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [7:0] r;
        bit o;
        sel(1'b0);
        xfer(op, -1, r, o);
        desel(1'b0);
    endtask

    task automatic send_addr(input logic [23:0] a);
        logic [7:0] r;
        bit o;
        xfer(a[23:16], -1, r, o);
        xfer(a[15:8], -1, r, o);
        xfer(a[7:0], -1, r, o);
    endtask

    task automatic wr(input logic [23:0] a, input int n,
                      input logic [7:0] d0, input logic [7:0] d1, input int hold_bit);
        logic [7:0] r;
        bit o;
        sel(1'b0);
        xfer(8'h02, -1, r, o);
        send_addr(a);
        xfer(d0, hold_bit, r, o);
        if (n > 1) xfer(d1, -1, r, o);
        desel(1'b0);
    endtask

    task automatic rd(input logic [23:0] a, input int n, input logic [7:0] e0,
                      input logic [7:0] e1, input bit mode3, input int hold_bit,
                      input string tag);
        logic [7:0] r;
        bit o;
        sel(mode3);
        xfer(8'h03, -1, r, o);
        send_addr(a);
        exp_q.push_back(e0); tag_q.push_back(tag);
        xfer(8'h00, hold_bit, r, o);
        got_q.push_back(r);
        if (n > 1) begin
            exp_q.push_back(e1); tag_q.push_back(tag);
            xfer(8'h00, -1, r, o);
            got_q.push_back(r);
        end
        desel(mode3);
    endtask

    task automatic rdsr(input logic [7:0] e, input string tag);
        logic [7:0] r;
        bit o;
        sel(1'b0);
        xfer(8'h05, -1, r, o);
        exp_q.push_back(e); tag_q.push_back(tag);
        xfer(8'h00, -1, r, o);
        got_q.push_back(r);
        desel(1'b0);
    endtask

    task automatic finish_run;
        wclk(4);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        bit o;
        wclk(4);
        rst_n = 1'b1;
        wclk(4);
        chk(miso_oe == 1'b0, "R8 reset oe", miso_oe, 0);
        chk(sleep_flag == 1'b0, "R10 reset sleep", sleep_flag, 0);

        rdsr(8'h00, "R7 status after reset");
        cmd(8'h06);
        rdsr(8'h02, "R3 status after enable");
        wr(24'h000003, 2, 8'h11, 8'h22, -1);
        rdsr(8'h00, "R3 flag cleared by write");
        rd(24'h000003, 2, 8'h11, 8'h22, 1'b0, -1, "R4 R1 burst read back");

        wr(24'h000003, 1, 8'h99, 8'h00, -1);
        rd(24'h000003, 1, 8'h11, 8'h00, 1'b0, -1, "R4 write without enable");

        cmd(8'h06);
        wr(24'h00000F, 2, 8'hA1, 8'hB2, -1);
        rd(24'h00000F, 2, 8'hA1, 8'hB2, 1'b0, -1, "R6 wrap burst");
        rd(24'hABCDE3, 1, 8'h11, 8'h00, 1'b0, -1, "R5 upper address ignored");
        rd(24'h000004, 1, 8'h22, 8'h00, 1'b1, -1, "R1 mode 3 read");

        // R11: unknown opcode then enable byte in same window
        sel(1'b0);
        xfer(8'hFF, -1, r, o);
        xfer(8'h06, -1, r, o);
        desel(1'b0);
        rdsr(8'h00, "R11 unknown opcode ignored");

        // R2: second opcode in one window does nothing
        sel(1'b0);
        xfer(8'h06, -1, r, o);
        xfer(8'h05, -1, r, o);
        xfer(8'h00, -1, r, o);
        chk(o == 1'b0, "R2 second opcode no output", o, 0);
        desel(1'b0);
        rdsr(8'h02, "R2 first opcode applied");
        cmd(8'h04);
        rdsr(8'h00, "R3 disable writes");

        // R10 sleep
        sel(1'b0);
        xfer(8'hB9, -1, r, o);
        wclk(4);
        chk(sleep_flag == 1'b1, "R10 sleep set", sleep_flag, 1);
        desel(1'b0);
        sel(1'b0);
        chk(sleep_flag == 1'b0, "R10 sleep cleared", sleep_flag, 0);
        desel(1'b0);

        // R9 hold mid-byte, write then read
        cmd(8'h06);
        wr(24'h000005, 1, 8'h3C, 8'h00, 3);
        rd(24'h000005, 1, 8'h3C, 8'h00, 1'b0, 4, "R9 hold transfer intact");

        // R7 status write
        cmd(8'h06);
        sel(1'b0); xfer(8'h01, -1, r, o); xfer(8'hFF, -1, r, o); desel(1'b0);
        rdsr(8'hFC, "R7 status write");
        sel(1'b0); xfer(8'h01, -1, r, o); xfer(8'h00, -1, r, o); desel(1'b0);
        rdsr(8'hFC, "R7 status write without enable");

        wclk(10);
        finish_run();
    end
endmodule